// File: doc/BRIEF.md
# Randomised Synchronous-Mode Request Strober

This block drives the synchronous-mode request lines of three bus register slices and brings their acknowledge lines back into a single control word. The three channels serve the instruction port (channel 0), the read/write data port (channel 1) and the peripheral port (channel 2). Software sets a static request level per channel. It can also arm a random-strobe mode that exercises the slices' mode-change handshake.

While a channel is armed and its static request is high, the channel counts down a pseudo-random interval and then inverts its request output. It does not move the request again until the synchronised acknowledge has reached the same level. A new interval is then loaded from a shared free-running LFSR. When the channel is not strobing, its request output follows the static bit. Acknowledge inputs pass through a two-flop synchronizer before they are used or read back.

Top module: `hs_strober`

## Requirements
- R1: While reset is held, `req_o` equals the `REQ_INIT` parameter and `ctl_rdata` reads `REQ_INIT` in bits 2:0 with every other bit 0.
- R2: The control word holds the static request bits in bits 2:0, the acknowledge bits in bits 5:3 and the strobe enables in bits 8:6, with bit n of each field belonging to channel n (0 instruction, 1 read/write, 2 peripheral). Bits 31:9 always read 0.
- R3: A write with `ctl_wr` high loads bits 2:0 and 8:6 from `ctl_wdata`. Values written to bits 5:3 and 31:9 are ignored.
- R4: A channel that is not strobing and has no strobe handshake outstanding drives `req_o` to its static bit one cycle after the register takes the value.
- R5: A channel whose strobe enable is 1 but whose static request bit is 0 never toggles its request.
- R6: After a strobe toggle, a channel's request output stays constant until the synchronised acknowledge equals it.
- R7: A strobing channel facing a responsive slice toggles repeatedly, and the intervals between toggles vary.
- R8: Bits 5:3 of `ctl_rdata` show `ack_async_i` as sampled two clock edges earlier. An acknowledge of 1 means the slice is in synchronous mode.
- R9: If strobing is switched off while a toggle waits for its acknowledge, the request holds until the acknowledge matches and then returns to the static bit.
- R10: Strobing on one channel leaves the request outputs of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read data |
| ack_async_i | input | 3 | Acknowledges from the slices, asynchronous |
| req_o | output | 3 | Synchronous-mode requests to the slices |

## Verification
The bench builds the block with `REQ_INIT` = 3'b010. This non-zero, mixed reset pattern shows per-bit reset values and exposes any swap of channel fields. It also sets `CNT_W` = 4, so no interval exceeds 16 cycles. A few thousand cycles then cover many complete handshakes on every strobing channel, along with toggles that wait against a held acknowledge. Acknowledges come either from a delayed echo model of the slices or directly from the bench, which allows exact checks of synchronizer latency and of mid-handshake disable.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int CTL_W  = 32;
    localparam int LFSR_W = 32;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;

    typedef enum logic [1:0] {
        CH_STATIC = 2'd0,
        CH_COUNT  = 2'd1,
        CH_WAIT   = 2'd2
    } ch_state_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] v);
        return (v >> 1) ^ (v[0] ? LFSR_TAPS : '0);
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_i;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hs_lfsr.sv
module hs_lfsr
    import hs_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 32'h1ACE_5EED
) (
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] value_o
);
    localparam logic [LFSR_W-1:0] SEED_NZ = (SEED == '0) ? 32'h1 : SEED;

    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED_NZ;
        else     state_q <= lfsr_step(state_q);
    end

    assign value_o = state_q;
endmodule

// File: rtl/hs_channel.sv
module hs_channel
    import hs_pkg::*;
#(
    parameter int   CNT_W    = 6,
    parameter logic REQ_INIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             static_i,
    input  logic             en_i,
    input  logic             ack_s_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             req_o,
    output logic             wait_o
);
    ch_state_e        state_q;
    logic             req_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active;

    assign active = en_i & static_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_STATIC;
            req_q   <= REQ_INIT;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                CH_STATIC: begin
                    req_q <= static_i;
                    cnt_q <= reload_i;
                    if (active) state_q <= CH_COUNT;
                end
                CH_COUNT: begin
                    if (!active) begin
                        req_q   <= static_i;
                        state_q <= CH_STATIC;
                    end else if (cnt_q == '0) begin
                        req_q   <= ~req_q;
                        state_q <= CH_WAIT;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                CH_WAIT: begin
                    if (ack_s_i == req_q) begin
                        cnt_q   <= reload_i;
                        state_q <= active ? CH_COUNT : CH_STATIC;
                    end
                end
                default: state_q <= CH_STATIC;
            endcase
        end
    end

    assign req_o  = req_q;
    assign wait_o = (state_q == CH_WAIT);
endmodule

// File: rtl/hs_strober.sv
module hs_strober
    import hs_pkg::*;
#(
    parameter int                 NCH      = 3,
    parameter int                 CNT_W    = 6,
    parameter logic [NCH-1:0]     REQ_INIT = '0,
    parameter logic [LFSR_W-1:0]  SEED     = 32'h1ACE_5EED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic [NCH-1:0]   ack_async_i,
    output logic [NCH-1:0]   req_o
);
    localparam int REQ_LSB = 0;
    localparam int ACK_LSB = NCH;
    localparam int EN_LSB  = 2 * NCH;
    localparam int USED_W  = 3 * NCH;

    logic [NCH-1:0]    static_q;
    logic [NCH-1:0]    en_q;
    logic [NCH-1:0]    ack_s;
    logic [NCH-1:0]    wait_vec;
    logic [LFSR_W-1:0] rnd;

    always_ff @(posedge clk) begin
        if (rst) begin
            static_q <= REQ_INIT;
            en_q     <= '0;
        end else if (ctl_wr) begin
            static_q <= ctl_wdata[REQ_LSB +: NCH];
            en_q     <= ctl_wdata[EN_LSB +: NCH];
        end
    end

    hs_sync #(.W(NCH), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ack_async_i),
        .q_o (ack_s)
    );

    hs_lfsr #(.SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .value_o (rnd)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            hs_channel #(
                .CNT_W    (CNT_W),
                .REQ_INIT (REQ_INIT[c])
            ) u_ch (
                .clk      (clk),
                .rst      (rst),
                .static_i (static_q[c]),
                .en_i     (en_q[c]),
                .ack_s_i  (ack_s[c]),
                .reload_i (rnd[(c*CNT_W) % (LFSR_W-CNT_W+1) +: CNT_W]),
                .req_o    (req_o[c]),
                .wait_o   (wait_vec[c])
            );
        end
    endgenerate

    always_comb begin
        ctl_rdata                  = '0;
        ctl_rdata[REQ_LSB +: NCH]  = static_q;
        ctl_rdata[ACK_LSB +: NCH]  = ack_s;
        ctl_rdata[EN_LSB +: NCH]   = en_q;
    end

    logic unused_wdata;
    assign unused_wdata = ^{ctl_wdata[CTL_W-1:USED_W], ctl_wdata[ACK_LSB +: NCH], rnd};
endmodule

// File: rtl/hs_strober_chk.sv
module hs_strober_chk #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst,
    input logic [31:0]    ctl_rdata,
    input logic [NCH-1:0] ack_async_i,
    input logic [NCH-1:0] req_o,
    input logic [NCH-1:0] static_q,
    input logic [NCH-1:0] en_q,
    input logic [NCH-1:0] ack_s,
    input logic [NCH-1:0] wait_vec
);
    logic [1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) run_cnt <= '0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[31:3*NCH] == '0);

    a_r8_ack_sync: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd2) |-> (ctl_rdata[NCH +: NCH] == $past(ack_async_i, 2)));

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
                (wait_vec[c] && (req_o[c] != ack_s[c])) |=> $stable(req_o[c]));

            a_r4_follow_static: assert property (@(posedge clk) disable iff (rst)
                (!(en_q[c] && static_q[c]) && !wait_vec[c]) |=> (req_o[c] == $past(static_q[c])));
        end
    endgenerate
endmodule

bind hs_strober hs_strober_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_rdata   (ctl_rdata),
    .ack_async_i (ack_async_i),
    .req_o       (req_o),
    .static_q    (static_q),
    .en_q        (en_q),
    .ack_s       (ack_s),
    .wait_vec    (wait_vec)
);

// File: tb/hs_strober_tb.sv
`timescale 1ns/1ps
module hs_strober_tb;
    localparam int          NCH   = 3;
    localparam int          CNT_W = 4;
    localparam logic [2:0]  RINIT = 3'b010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic [2:0]  ack_async;
    logic [2:0]  req;

    logic [2:0]  ack_sel = 3'b000;
    logic [2:0]  ack_drv = 3'b000;
    logic [2:0]  echo_d1 = '0, echo_d2 = '0, echo_q = '0;

    int tests = 0;
    int fails = 0;

    bit mon_en = 1'b0;
    int toggles [3];
    int viol;
    int gap [3];
    int gmin [3];
    int gmax [3];
    logic [2:0] prev_req;

    always #2.5 clk = ~clk;

    hs_strober #(.NCH(NCH), .CNT_W(CNT_W), .REQ_INIT(RINIT)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .ctl_rdata   (ctl_rdata),
        .ack_async_i (ack_async),
        .req_o       (req)
    );

    // slice model: acknowledge echoes request after three cycles
    always @(posedge clk) begin
        echo_d1 <= req;
        echo_d2 <= echo_d1;
        echo_q  <= echo_d2;
    end
    assign ack_async = (ack_sel & ack_drv) | (~ack_sel & echo_q);

    always @(negedge clk) begin
        if (mon_en) begin
            for (int c = 0; c < 3; c++) begin
                gap[c]++;
                if (req[c] != prev_req[c]) begin
                    if (ack_async[c] != prev_req[c]) viol++;
                    if (toggles[c] > 0) begin
                        if (gap[c] < gmin[c]) gmin[c] = gap[c];
                        if (gap[c] > gmax[c]) gmax[c] = gap[c];
                    end
                    toggles[c]++;
                    gap[c] = 0;
                end
            end
        end
        prev_req = req;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        cyc(4);
        check(req == RINIT, "R1 req in reset", {29'd0, req}, {29'd0, RINIT});
        check(ctl_rdata == {29'd0, RINIT}, "R1 rdata in reset", ctl_rdata, {29'd0, RINIT});
        rst = 1'b0;
        cyc(10);
        check(ctl_rdata[31:9] == '0, "R2 upper bits zero", ctl_rdata, 32'h0);
        check(ctl_rdata[5:3] == req, "R8 ack readback settled", {29'd0, ctl_rdata[5:3]}, {29'd0, req});
    endtask

    task automatic t_static;
        wr(32'h0000_0005);
        check(req == RINIT, "R4 req not yet moved", {29'd0, req}, {29'd0, RINIT});
        cyc(1);
        check(req == 3'b101, "R4 req follows 101", {29'd0, req}, 32'h5);
        wr(32'h0000_0002);
        cyc(1);
        check(req == 3'b010, "R4 req follows 010", {29'd0, req}, 32'h2);
    endtask

    task automatic t_write_mask;
        ack_sel = 3'b111;
        ack_drv = 3'b000;
        wr(32'hFFFF_FE3F);
        cyc(4);
        check(ctl_rdata == 32'h0000_0007, "R3 written ack/upper bits ignored", ctl_rdata, 32'h7);
        check(req == 3'b111, "R4 req follows 111", {29'd0, req}, 32'h7);
    endtask

    task automatic t_ack_sync;
        ack_sel = 3'b111;
        ack_drv = 3'b000;
        cyc(3);
        ack_drv = 3'b101;
        cyc(1);
        check(ctl_rdata[5:3] == 3'b000, "R8 ack not visible after one edge", {29'd0, ctl_rdata[5:3]}, 32'h0);
        cyc(1);
        check(ctl_rdata[5:3] == 3'b101, "R8 ack visible after two edges", {29'd0, ctl_rdata[5:3]}, 32'h5);
        ack_drv = 3'b010;
        cyc(2);
        check(ctl_rdata[5:3] == 3'b010, "R8 ack pattern 010", {29'd0, ctl_rdata[5:3]}, 32'h2);
    endtask

    task automatic t_strobe;
        ack_sel = 3'b000;
        wr(32'h0000_0005);
        cyc(12);
        for (int c = 0; c < 3; c++) begin
            toggles[c] = 0; gap[c] = 0; gmin[c] = 1 << 30; gmax[c] = 0;
        end
        viol = 0;
        prev_req = req;
        mon_en = 1'b1;
        wr(32'h0000_01C5);
        cyc(3000);
        mon_en = 1'b0;
        check(toggles[0] > 20, "R7 ch0 toggles", toggles[0], 21);
        check(toggles[2] > 20, "R7 ch2 toggles", toggles[2], 21);
        check(gmax[0] > gmin[0], "R7 ch0 intervals vary", gmax[0], gmin[0] + 1);
        check(toggles[1] == 0 && req[1] == 1'b0, "R5 ch1 gated by static bit", toggles[1], 0);
        check(viol == 0, "R6 toggle only after ack matched", viol, 0);
        wr(32'h0000_0005);
        cyc(20);
        check(req == 3'b101, "R9 back to static after disable", {29'd0, req}, 32'h5);
    endtask

    task automatic t_disable_pending;
        int n;
        ack_sel = 3'b111;
        ack_drv = 3'b111;
        wr(32'h0000_0007);
        cyc(8);
        wr(32'h0000_0047);
        n = 0;
        while (req[0] == 1'b1 && n < 200) begin
            cyc(1);
            n++;
        end
        check(req[0] == 1'b0, "R7 ch0 toggled toward 0", {31'd0, req[0]}, 32'h0);
        wr(32'h0000_0007);
        cyc(20);
        check(req[0] == 1'b0, "R9 R6 request held while ack pending", {31'd0, req[0]}, 32'h0);
        check(req[2:1] == 2'b11, "R10 other channels untouched", {30'd0, req[2:1]}, 32'h3);
        ack_drv[0] = 1'b0;
        cyc(6);
        check(req[0] == 1'b1, "R9 request returns to static", {31'd0, req[0]}, 32'h1);
    endtask

    task automatic t_single_channel;
        ack_sel = 3'b000;
        wr(32'h0000_0007);
        cyc(12);
        for (int c = 0; c < 3; c++) toggles[c] = 0;
        viol = 0;
        prev_req = req;
        mon_en = 1'b1;
        wr(32'h0000_0087);
        cyc(600);
        mon_en = 1'b0;
        check(toggles[1] > 5, "R7 ch1 toggles alone", toggles[1], 6);
        check(toggles[0] == 0 && toggles[2] == 0, "R10 ch0/ch2 steady", toggles[0] + toggles[2], 0);
        check(viol == 0, "R6 handshake order ch1", viol, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_static();
        t_write_mask();
        t_ack_sync();
        t_strobe();
        t_disable_pending();
        t_single_channel();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule